// File: doc/BRIEF.md
# DRAM Parallel Test Mode Compressor

This block is a clock-sampled behavioural model of a small DRAM array with a built-in parallel test mode. The active-low row strobe, column strobe and write enable are sampled on every rising clock edge. Their order of falling decides what a cycle is: a row access, a refresh, or the command that enters test mode. That command is a refresh cycle in which both the column strobe and the write enable are already low when the row strobe falls.

In test mode, the two lowest column address bits are ignored. A write copies each data bit into the four cells that differ only in those two bits. A read compresses each such group of four cells to a single level per data bit: high when the four cells hold the same value, low when they do not. A tester can therefore check a full array in a quarter of the column cycles. A refresh with the write enable high ends test mode. So does a row cycle that never strobes a column. In normal mode, each column cycle reads or writes one word at the full column address.

The data input and the data output are separate ports. A drive-enable output stands in for the high-impedance state of a shared data pin.

Top module: `dram_ptest_core`

## Requirements
- R1: Test mode is entered when the row strobe is sampled falling while the column strobe and the write enable are both low. The `test_mode` output is high from the next clock.
- R2: In test mode, column address bits [1:0] have no effect. A read at any of the four column addresses of one group returns the same result.
- R3: A test-mode write stores each `din` bit into all four cells whose column addresses differ only in bits [1:0].
- R4: On a test-mode read, `dout` bit b is 1 when bit b of the four cells in the addressed group are all 1 or all 0.
- R5: On a test-mode read, `dout` bit b is 0 when bit b of those four cells are not all equal.
- R6: Test mode is left at either of two events, and `test_mode` is low afterwards:
  - a refresh in which the row strobe falls while the column strobe is low and the write enable is high;
  - a row cycle in which no column strobe falls before the row strobe rises.
- R7: In normal mode, a write stores `din` at exactly the full row and column address. A read returns that word, and the other three cells of its group are unchanged.
- R8: A refresh cycle, including the test-mode entry cycle, writes no cell and never sets `dout_oe`, whatever the values of `din` and `we_n`.
- R9: `dout_oe` is low whenever `cas_n` or `oe_n` is high. During a read column cycle with both low, `dout_oe` is high from the clock after the column strobe is sampled low.
- R10: `test_mode` changes only at a sampled row-strobe edge. Reset clears `test_mode`, `dout_oe` and every cell to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at the column strobe |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (4) | Row address at the row strobe, column address at the column strobe |
| din | input | IO_W (4) | Write data |
| dout | output | IO_W (4) | Read data, or per-bit pass/fail in test mode |
| dout_oe | output | 1 | Output drive enable; low means high impedance |
| test_mode | output | 1 | High while parallel test mode is active |

## Verification
Two functions can land on the same sampling edge: the mode decode and the column-cycle logic. In the entry command, the column strobe and the write enable are already low when the row strobe falls, which is also the pattern of a write. The bench provokes this overlap by driving `din` to all ones and `oe_n` low during that entry cycle. It then judges that `test_mode` rose, that `dout_oe` stayed low, and that a later normal-mode read of the addressed cell still returns zero.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;

  // Number of cells merged per data bit in test mode.
  localparam int GRP_N = 4;

  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ACCESS  = 2'd1,
    CYC_REFRESH = 2'd2
  } cyc_kind_e;

  // Pass level for one data bit: high when all cells in the group agree.
  function automatic logic group_same(input logic [GRP_N-1:0] cells);
    return (&cells) | ~(|cells);
  endfunction

endpackage

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode
  import dram_ptest_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             test_mode,
  output logic             rd_act,
  output logic             wr_fire,
  output logic             wr_bcast
);

  logic      ras_q, cas_q, saw_cas;
  cyc_kind_e kind;

  // Named strobe events, also used by the assertions below.
  logic ras_fall_ev, ras_rise_ev, cas_fall_ev, cas_rise_ev, col_strobe;
  assign ras_fall_ev = ras_q & ~ras_n;
  assign ras_rise_ev = ~ras_q & ras_n;
  assign cas_fall_ev = cas_q & ~cas_n;
  assign cas_rise_ev = ~cas_q & cas_n;
  assign col_strobe  = cas_fall_ev & (kind == CYC_ACCESS) & ~ras_n;
  assign wr_fire     = col_strobe & ~we_n;
  assign wr_bcast    = test_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      kind      <= CYC_IDLE;
      saw_cas   <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      test_mode <= 1'b0;
      rd_act    <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall_ev) begin
        if (!cas_n) begin
          // Column-before-row: refresh; write enable picks entry or exit.
          kind      <= CYC_REFRESH;
          test_mode <= ~we_n;
          rd_act    <= 1'b0;
        end else begin
          kind    <= CYC_ACCESS;
          row_q   <= addr[ROW_W-1:0];
          saw_cas <= 1'b0;
        end
      end else if (ras_rise_ev) begin
        kind <= CYC_IDLE;
        if (kind == CYC_ACCESS && !saw_cas) test_mode <= 1'b0;
      end
      if (col_strobe) begin
        col_q   <= addr[COL_W-1:0];
        saw_cas <= 1'b1;
        rd_act  <= we_n;
      end
      if (cas_rise_ev) rd_act <= 1'b0;
    end
  end

  a_r1_wcbr_enters : assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall_ev && !cas_n && !we_n) |=> test_mode);

  a_r6_cbr_exits : assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall_ev && !cas_n && we_n) |=> !test_mode);

  a_r10_mode_on_ras_only : assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_fall_ev || ras_rise_ev) |=> $stable(test_mode));

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array
  import dram_ptest_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 4,
  parameter int IO_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bcast,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [IO_W-1:0]  wr_data,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic [IO_W-1:0]  grp_o [GRP_N]
);

  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [IO_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < GRP_N; k++) begin
        if (wr_bcast || wr_col[1:0] == k[1:0])
          mem[{wr_row, wr_col[COL_W-1:2], k[1:0]}] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_rd
    assign grp_o[g] = mem[{rd_row, rd_col[COL_W-1:2], 2'(g)}];
  end

endmodule

// File: rtl/dram_read_compress.sv
module dram_read_compress
  import dram_ptest_pkg::*;
#(
  parameter int IO_W = 4
) (
  input  logic [IO_W-1:0] grp   [GRP_N],
  input  logic [1:0]      col_lo,
  input  logic            test_mode,
  output logic [IO_W-1:0] rdata
);

  for (genvar b = 0; b < IO_W; b++) begin : g_bit
    logic [GRP_N-1:0] cells;
    for (genvar g = 0; g < GRP_N; g++) begin : g_cell
      assign cells[g] = grp[g][b];
    end
    assign rdata[b] = test_mode ? group_same(cells) : cells[col_lo];
  end

endmodule

// File: rtl/dram_ptest_core.sv
module dram_ptest_core
  import dram_ptest_pkg::*;
#(
  parameter  int ROW_W  = 3,
  parameter  int COL_W  = 4,
  parameter  int IO_W   = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   din,
  output logic [IO_W-1:0]   dout,
  output logic              dout_oe,
  output logic              test_mode
);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             rd_act, wr_fire, wr_bcast;
  logic [IO_W-1:0]  grp [GRP_N];
  logic [IO_W-1:0]  rdata;

  dram_strobe_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .row_q(row_q), .col_q(col_q), .test_mode(test_mode),
    .rd_act(rd_act), .wr_fire(wr_fire), .wr_bcast(wr_bcast)
  );

  dram_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .IO_W(IO_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_bcast(wr_bcast),
    .wr_row(row_q), .wr_col(addr[COL_W-1:0]), .wr_data(din),
    .rd_row(row_q), .rd_col(col_q), .grp_o(grp)
  );

  dram_read_compress #(.IO_W(IO_W)) u_cmp (
    .grp(grp), .col_lo(col_q[1:0]), .test_mode(test_mode), .rdata(rdata)
  );

  assign dout    = rdata;
  assign dout_oe = rd_act & ~cas_n & ~oe_n;

  // R3: after a broadcast write the addressed group reads back as all-pass.
  a_r3_bcast_uniform : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_bcast) |=> (rdata == '1));

  // R7: a normal write is visible at its own address on the next clock.
  a_r7_single_word : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_bcast) |=> (rdata == $past(din)));

endmodule

// File: tb/sim_dram_ptest_core.sv
module sim_dram_ptest_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       dout_oe, test_mode;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_ptest_core u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .test_mode(test_mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] row, input logic [3:0] col,
                          input logic [3:0] data);
    @(negedge clk) ras_n = 1'b0; addr = {1'b0, row};
    @(negedge clk) addr = col; din = data; we_n = 1'b0; cas_n = 1'b0;
    @(negedge clk) cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk) ras_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [2:0] row, input logic [3:0] col,
                         input logic use_oe, output logic [3:0] d,
                         output logic oe);
    @(negedge clk) ras_n = 1'b0; addr = {1'b0, row};
    @(negedge clk) addr = col; cas_n = 1'b0; we_n = 1'b1;
    @(negedge clk) oe_n = ~use_oe;
    @(negedge clk) d = dout; oe = dout_oe; oe_n = 1'b1; cas_n = 1'b1;
    @(negedge clk) ras_n = 1'b1;
    @(negedge clk);
  endtask

  // Column-before-row refresh; we=0 gives the test-mode entry command.
  task automatic cbr(input logic we, output logic oe_seen);
    @(negedge clk) cas_n = 1'b0; we_n = we; din = 4'hF; addr = '0; oe_n = 1'b0;
    @(negedge clk) ras_n = 1'b0;
    @(negedge clk) oe_seen = dout_oe; ras_n = 1'b1;
    @(negedge clk) cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; din = '0;
    @(negedge clk);
  endtask

  task automatic ras_only(input logic [2:0] row);
    @(negedge clk) ras_n = 1'b0; addr = {1'b0, row};
    @(negedge clk);
    @(negedge clk) ras_n = 1'b1;
    @(negedge clk);
  endtask

  // {op[2:0], row[2:0], col[3:0], data[3:0], exp[3:0], req[3:0]}
  // op: 0 write, 1 read (exp = dout), 2 entry, 3 refresh exit, 4 row-only exit
  localparam logic [21:0] VEC [16] = '{
    {3'd0, 3'd1, 4'd5,  4'hA, 4'h0, 4'd7},   // R7 normal write
    {3'd1, 3'd1, 4'd5,  4'h0, 4'hA, 4'd7},   // R7 read own word
    {3'd1, 3'd1, 4'd4,  4'h0, 4'h0, 4'd7},   // R7 neighbour untouched
    {3'd2, 3'd0, 4'd0,  4'h0, 4'h1, 4'd1},   // R1 entry
    {3'd0, 3'd2, 4'd8,  4'h6, 4'h0, 4'd3},   // R3 broadcast write
    {3'd1, 3'd2, 4'd9,  4'h0, 4'hF, 4'd4},   // R4 uniform group
    {3'd1, 3'd2, 4'd11, 4'h0, 4'hF, 4'd2},   // R2 low bits ignored
    {3'd1, 3'd1, 4'd6,  4'h0, 4'h5, 4'd5},   // R5 cells 0,A,0,0
    {3'd3, 3'd0, 4'd0,  4'h0, 4'h0, 4'd6},   // R6 refresh exit
    {3'd1, 3'd2, 4'd10, 4'h0, 4'h6, 4'd3},   // R3 copy at col 10
    {3'd1, 3'd2, 4'd8,  4'h0, 4'h6, 4'd3},   // R3 copy at col 8
    {3'd0, 3'd2, 4'd9,  4'h7, 4'h0, 4'd7},   // R7 normal write
    {3'd2, 3'd0, 4'd0,  4'h0, 4'h1, 4'd1},   // R1 entry again
    {3'd1, 3'd2, 4'd8,  4'h0, 4'hE, 4'd5},   // R5 cells 6,7,6,6
    {3'd4, 3'd3, 4'd0,  4'h0, 4'h0, 4'd6},   // R6 row-only exit
    {3'd1, 3'd2, 4'd9,  4'h0, 4'h7, 4'd7}    // R7 normal read
  };

  initial begin
    logic [3:0] d;
    logic       oe;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset test_mode", test_mode, 0);
    check("R9 reset dout_oe", dout_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      logic [2:0] op, row;
      logic [3:0] col, dat, ex, rq;
      {op, row, col, dat, ex, rq} = VEC[i];
      case (op)
        3'd0: do_write(row, col, dat);
        3'd1: begin
          do_read(row, col, 1'b1, d, oe);
          check($sformatf("R%0d vec %0d read", rq, i), d, ex);
          check($sformatf("R9 vec %0d drive", i), oe, 1);
        end
        3'd2: begin cbr(1'b0, oe); check($sformatf("R%0d vec %0d mode", rq, i), test_mode, ex); end
        3'd3: begin cbr(1'b1, oe); check($sformatf("R%0d vec %0d mode", rq, i), test_mode, ex); end
        default: begin ras_only(row); check($sformatf("R%0d vec %0d mode", rq, i), test_mode, ex); end
      endcase
    end

    // R8: entry cycle with din all ones and oe_n low must not write or drive.
    cbr(1'b0, oe);
    check("R8 no drive in entry", oe, 0);
    check("R1 entered", test_mode, 1);
    // R10: a column strobe pulse without a row strobe leaves the mode alone.
    @(negedge clk) cas_n = 1'b0;
    @(negedge clk) cas_n = 1'b1;
    @(negedge clk);
    check("R10 cas-only keeps mode", test_mode, 1);
    cbr(1'b1, oe);
    check("R6 exit", test_mode, 0);
    do_read(3'd0, 4'd0, 1'b1, d, oe);
    check("R8 cell untouched", d, 0);
    // R9: read with oe_n held high is never driven.
    do_read(3'd1, 4'd5, 1'b0, d, oe);
    check("R9 oe_n high", oe, 0);
    check("R9 idle", dout_oe, 0);
    // R10: reset inside test mode clears the mode and the cells.
    cbr(1'b0, oe);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears mode", test_mode, 0);
    rst_n = 1'b1;
    do_read(3'd1, 4'd5, 1'b1, d, oe);
    check("R10 reset clears cells", d, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule